// File: doc/BRIEF.md
# Tiered Reset Release Controller

This block turns one combined reset condition into the grouped reset outputs of a system clocked by its slowest synchronous clock. The combined condition is high when any of three things holds: a reset request that has already been filtered and synchronized upstream, the internal power-on window, or a low clock-lock input. While the condition holds, every output is driven active. All outputs become active together on one clock edge.

Once the condition clears, the outputs release in three tiers. The bus and interconnect group releases first. The peripheral group releases a fixed gap of clocks later, and the processor group releases the same gap after the peripherals. If the condition returns at any point in the sequence, every output becomes active again and the sequence starts over from the first tier.

Each group is replicated into a parameter-chosen number of copies, and each copy has its own flip-flop so that loads can be spread. The bus and peripheral groups also come in active-low copies that follow the timing of their active-high counterparts. The power-on window comes from a counter that starts at zero from its initial value, so no reset input is needed.

Top module: `rst_seq_ctrl`

## Requirements
- R1: When `ext_rst_req` is sampled high on a clock edge, every output is active after the second edge that follows, and all outputs turn active on the same edge.
- R2: When the combined condition is first sampled clear on an edge, the bus group (`bus_rst` high to low, `ic_rst_n` low to high) releases on the next edge, while the peripheral and processor groups stay active.
- R3: The peripheral group (`periph_rst`, `periph_rst_n`) releases exactly TIER_GAP (default 16) clocks after the bus group, and never before it.
- R4: The processor group (`cpu_rst`) releases exactly TIER_GAP clocks after the peripheral group, and never before it.
- R5: From time zero every output is active. With lock high and no request, the power-on window holds them for POR_CYCLES (default 16) edges, and the bus group releases on edge POR_CYCLES+2.
- R6: While `clk_locked` is low all outputs stay active, for any length of time. After lock is sampled high, the bus group releases on the next edge and the tiered release follows.
- R7: A request that appears during the release sequence drives every output active again, and the sequence restarts: the peripheral group then releases TIER_GAP clocks after the new bus release.
- R8: The active-high outputs are active at 1 and the `_n` outputs are active at 0. All copies of a group carry the same value, and `ic_rst_n` and `periph_rst_n` are the inverse of `bus_rst` and `periph_rst`.

Each requirement is checked in the bench by an external reset pulse, a mid-sequence reassertion, and a lock drop, and is also exercised by the run-in from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slowest synchronous system clock |
| ext_rst_req | input | 1 | Qualified, synchronized reset request, active high |
| clk_locked | input | 1 | Clock generator lock, high when stable |
| bus_rst | output | BUS_COPIES | Bus structure resets, active high |
| ic_rst_n | output | IC_N_COPIES | Interconnect resets, active low |
| periph_rst | output | PERIPH_COPIES | Peripheral resets, active high |
| periph_rst_n | output | PERIPH_N_COPIES | Peripheral resets, active low |
| cpu_rst | output | CPU_COPIES | Processor core resets, active high |

## Verification
A wrong release counter shows up at the ports as a shifted tier gap, so it is measured as an exact clock count between releases, not just as an ordering. A hold flag that clears too early or too late moves the first bus release by a cycle against the edge on which the condition was sampled clear, and the bench checks that edge on both sides. A fault in a single copy flip-flop or in polarity breaks copy agreement on the very next sample, and every sample in the bench compares all copies and both polarities. A restart that is not handled would release peripherals early after a mid-sequence pulse, and this shows at the gap length within 16 clocks.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    TIER_BUS    = 2'd0,
    TIER_PERIPH = 2'd1,
    TIER_CPU    = 2'd2
  } tier_e;

  localparam int unsigned NUM_TIERS = 3;

  // Count value at which a tier is allowed to let go.
  function automatic int unsigned tier_threshold(input int unsigned tier,
                                                 input int unsigned gap);
    return tier * gap;
  endfunction

  // Bits needed to hold values 0..maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // A tier stays held while the sequencer holds or its threshold is unmet.
  function automatic logic tier_held(input logic        seq_hold,
                                     input int unsigned cnt,
                                     input int unsigned tier,
                                     input int unsigned gap);
    return seq_hold || (cnt < tier_threshold(tier, gap));
  endfunction

endpackage

// File: rtl/rst_seq_por.sv
module rst_seq_por #(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk,
  output logic por_busy
);
  import rst_seq_pkg::*;

  localparam int unsigned POR_W = cnt_width(POR_CYCLES);

  // Starts at zero from its initial value; no reset input.
  logic [POR_W-1:0] por_cnt = '0;

  always_ff @(posedge clk) begin
    if (por_cnt < POR_W'(POR_CYCLES)) por_cnt <= por_cnt + 1'b1;
  end

  assign por_busy = (por_cnt < POR_W'(POR_CYCLES));

  always_comb begin
    AST_POR_SATURATES: assert (por_cnt <= POR_W'(POR_CYCLES)); // R5
  end

endmodule

// File: rtl/rst_seq_tier_cnt.sv
module rst_seq_tier_cnt #(
  parameter int unsigned TIER_GAP = 16
) (
  input  logic                                               clk,
  input  logic                                               hold_in,
  input  logic                                               por_busy,
  output logic                                               seq_hold,
  output logic [rst_seq_pkg::cnt_width(2*TIER_GAP)-1:0]      rel_cnt,
  output logic [rst_seq_pkg::NUM_TIERS-1:0]                  tier_req
);
  import rst_seq_pkg::*;

  localparam int unsigned CNT_MAX = tier_threshold(NUM_TIERS - 1, TIER_GAP);
  localparam int unsigned CNT_W   = cnt_width(CNT_MAX);

  logic             hold_q = 1'b1;
  logic [CNT_W-1:0] cnt_q  = '0;

  always_ff @(posedge clk) begin
    if (hold_in) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= 1'b0;
      if (!hold_q && (cnt_q < CNT_W'(CNT_MAX))) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign seq_hold = hold_q;
  assign rel_cnt  = cnt_q;

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    assign tier_req[t] = tier_held(hold_q, 32'(cnt_q), t, TIER_GAP);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (por_busy)
    cnt_q <= CNT_W'(CNT_MAX)); // R4

  AST_HOLD_RESTARTS: assert property (@(posedge clk) disable iff (por_busy)
    hold_in |=> (hold_q && cnt_q == '0)); // R7

  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (por_busy)
    (!hold_in && !hold_q && cnt_q < CNT_W'(CNT_MAX)) |=> cnt_q == $past(cnt_q) + 1'b1); // R3

endmodule

// File: rtl/rst_seq_fanout.sv
module rst_seq_fanout #(
  parameter int unsigned COPIES     = 1,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              hold_req,
  output logic [COPIES-1:0] rst_out
);
  localparam logic ON_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    logic cp_q = ON_LVL;
    always_ff @(posedge clk) begin
      cp_q <= hold_req ? ON_LVL : ~ON_LVL;
    end
    assign rst_out[g] = cp_q;
  end

  always_comb begin
    AST_COPIES_AGREE: assert (($countones(rst_out) == 0) ||
                              ($countones(rst_out) == COPIES)); // R8
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned BUS_COPIES      = 1,
  parameter int unsigned IC_N_COPIES     = 1,
  parameter int unsigned PERIPH_COPIES   = 1,
  parameter int unsigned PERIPH_N_COPIES = 1,
  parameter int unsigned CPU_COPIES      = 1,
  parameter int unsigned TIER_GAP        = 16,
  parameter int unsigned POR_CYCLES      = 16
) (
  input  logic                       clk,
  input  logic                       ext_rst_req,
  input  logic                       clk_locked,
  output logic [BUS_COPIES-1:0]      bus_rst,
  output logic [IC_N_COPIES-1:0]     ic_rst_n,
  output logic [PERIPH_COPIES-1:0]   periph_rst,
  output logic [PERIPH_N_COPIES-1:0] periph_rst_n,
  output logic [CPU_COPIES-1:0]      cpu_rst
);
  import rst_seq_pkg::*;

  localparam int unsigned CNT_W = cnt_width(2 * TIER_GAP);

  logic                 por_busy;
  logic                 hold_all;
  logic                 seq_hold;
  logic [CNT_W-1:0]     rel_cnt;
  logic [NUM_TIERS-1:0] tier_req;

  rst_seq_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk      (clk),
    .por_busy (por_busy)
  );

  assign hold_all = por_busy | ext_rst_req | ~clk_locked;

  rst_seq_tier_cnt #(.TIER_GAP(TIER_GAP)) u_cnt (
    .clk      (clk),
    .hold_in  (hold_all),
    .por_busy (por_busy),
    .seq_hold (seq_hold),
    .rel_cnt  (rel_cnt),
    .tier_req (tier_req)
  );

  rst_seq_fanout #(.COPIES(BUS_COPIES), .ACTIVE_LOW(1'b0)) u_bus (
    .clk (clk), .hold_req (tier_req[TIER_BUS]), .rst_out (bus_rst));

  rst_seq_fanout #(.COPIES(IC_N_COPIES), .ACTIVE_LOW(1'b1)) u_ic_n (
    .clk (clk), .hold_req (tier_req[TIER_BUS]), .rst_out (ic_rst_n));

  rst_seq_fanout #(.COPIES(PERIPH_COPIES), .ACTIVE_LOW(1'b0)) u_per (
    .clk (clk), .hold_req (tier_req[TIER_PERIPH]), .rst_out (periph_rst));

  rst_seq_fanout #(.COPIES(PERIPH_N_COPIES), .ACTIVE_LOW(1'b1)) u_per_n (
    .clk (clk), .hold_req (tier_req[TIER_PERIPH]), .rst_out (periph_rst_n));

  rst_seq_fanout #(.COPIES(CPU_COPIES), .ACTIVE_LOW(1'b0)) u_cpu (
    .clk (clk), .hold_req (tier_req[TIER_CPU]), .rst_out (cpu_rst));

  AST_REQ_ASSERTS_ALL: assert property (@(posedge clk) disable iff (por_busy)
    ext_rst_req |=> ##1 (bus_rst[0] && periph_rst[0] && cpu_rst[0])); // R1

  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (por_busy)
    $rose(bus_rst[0]) |-> (periph_rst[0] && cpu_rst[0] && !ic_rst_n[0])); // R1

  AST_BUS_FIRST: assert property (@(posedge clk) disable iff (por_busy)
    $fell(seq_hold) |=> (!bus_rst[0] && periph_rst[0] && cpu_rst[0])); // R2

  AST_PERIPH_AFTER_BUS: assert property (@(posedge clk) disable iff (por_busy)
    !periph_rst[0] |-> !bus_rst[0]); // R3

  AST_CPU_AFTER_PERIPH: assert property (@(posedge clk) disable iff (por_busy)
    !cpu_rst[0] |-> !periph_rst[0]); // R4

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (por_busy)
    !clk_locked |=> ##1 (bus_rst[0] && periph_rst[0] && cpu_rst[0])); // R6

  AST_POLARITY_PAIR: assert property (@(posedge clk)
    (bus_rst[0] != ic_rst_n[0]) && (periph_rst[0] != periph_rst_n[0])); // R8

endmodule

// File: tb/tb_rst_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rst_seq_ctrl;

  localparam int NB = 2, NI = 2, NP = 3, NPN = 4, NC = 2;
  localparam int GAP = 16, POR = 16;

  logic clk = 1'b0;
  logic ext_rst_req = 1'b0;
  logic clk_locked = 1'b1;
  logic [NB-1:0]  bus_rst;
  logic [NI-1:0]  ic_rst_n;
  logic [NP-1:0]  periph_rst;
  logic [NPN-1:0] periph_rst_n;
  logic [NC-1:0]  cpu_rst;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;

  rst_seq_ctrl #(
    .BUS_COPIES(NB), .IC_N_COPIES(NI), .PERIPH_COPIES(NP),
    .PERIPH_N_COPIES(NPN), .CPU_COPIES(NC), .TIER_GAP(GAP), .POR_CYCLES(POR)
  ) dut (
    .clk(clk), .ext_rst_req(ext_rst_req), .clk_locked(clk_locked),
    .bus_rst(bus_rst), .ic_rst_n(ic_rst_n), .periph_rst(periph_rst),
    .periph_rst_n(periph_rst_n), .cpu_rst(cpu_rst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  // {bus, periph, cpu} active flags taken from copy 0 of each group.
  function automatic logic [2:0] st();
    return {bus_rst[0], periph_rst[0], cpu_rst[0]};
  endfunction

  function automatic bit copies_ok();
    return (bus_rst == {NB{bus_rst[0]}}) && (ic_rst_n == {NI{~bus_rst[0]}}) &&
           (periph_rst == {NP{periph_rst[0]}}) &&
           (periph_rst_n == {NPN{~periph_rst[0]}}) && (cpu_rst == {NC{cpu_rst[0]}});
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [2:0] exp);
    check(tag, int'(st()), int'(exp));
    check("R8 copies/polarity", int'(copies_ok()), 1);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_edge(input int n);
    while (cyc < n) step();
  endtask

  // Count clocks from now until group bit goes inactive.
  task automatic gap_to_release(input int idx, output int n);
    n = 0;
    while (st()[idx] && n < 200) begin step(); n++; end
  endtask

  task automatic t_power_on();
    int g;
    #1;
    check_state("R5 reset state at time zero", 3'b111);
    to_edge(POR + 1);
    check_state("R5 held through power-on", 3'b111);
    step();
    check_state("R2 bus first after power-on", 3'b011);
    gap_to_release(1, g);
    check("R3 periph gap", g, GAP);
    gap_to_release(0, g);
    check("R4 cpu gap", g, GAP);
    check_state("R4 all released", 3'b000);
  endtask

  task automatic t_ext_pulse();
    int g;
    step(); ext_rst_req = 1'b1;
    step();
    check_state("R1 no change one edge after request", 3'b000);
    step();
    check_state("R1 all active together", 3'b111);
    repeat (4) step();
    ext_rst_req = 1'b0;
    step();
    check_state("R2 still held one edge after clear", 3'b111);
    step();
    check_state("R2 bus releases first", 3'b011);
    gap_to_release(1, g);
    check("R3 periph gap after ext", g, GAP);
    gap_to_release(0, g);
    check("R4 cpu gap after ext", g, GAP);
  endtask

  task automatic t_reassert();
    int g;
    step(); ext_rst_req = 1'b1;
    repeat (2) step();
    ext_rst_req = 1'b0;
    repeat (2) step();
    check_state("R7 setup bus released", 3'b011);
    repeat (5) step();
    ext_rst_req = 1'b1;
    step(); ext_rst_req = 1'b0;
    check_state("R7 one edge after pulse", 3'b011);
    step();
    check_state("R7 all active again", 3'b111);
    step();
    check_state("R7 bus released again", 3'b011);
    gap_to_release(1, g);
    check("R7 restart full periph gap", g, GAP);
    gap_to_release(0, g);
    check("R7 cpu gap after restart", g, GAP);
  endtask

  task automatic t_lock();
    int g;
    step(); clk_locked = 1'b0;
    repeat (2) step();
    check_state("R6 lock loss asserts all", 3'b111);
    repeat (60) step();
    check_state("R6 held while unlocked", 3'b111);
    clk_locked = 1'b1;
    step();
    check_state("R6 held one edge after lock", 3'b111);
    step();
    check_state("R6 bus releases after lock", 3'b011);
    gap_to_release(1, g);
    check("R6 periph gap after lock", g, GAP);
    gap_to_release(0, g);
    check("R6 cpu gap after lock", g, GAP);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    t_power_on();
    t_ext_pulse();
    t_reassert();
    t_lock();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired at edge %0d: actual 0 expected 1", cyc);
    finish_run();
  end

endmodule